// File: doc/BRIEF.md
# Load/Store Issue Cost Controller

This block sits at the issue point of a small in-order core and decides how many cycles each decoded instruction holds the issue slot. Descriptors arrive one at a time over a valid/ready handshake. Each gives a class, a destination register, a base register, an offset register and two flags: base writeback and register offset. The block keeps a one-entry history of the last accepted instruction. It uses this history to remove a cycle when a load-like instruction is followed by an independent memory access. It adds a cycle when an address needs a register that the instruction just before has computed.

While an instruction is being costed, `in_ready` stays low, so the descriptor stream is held for the stall cycles. A single `mem_stall` input freezes the remaining-cycle count and adds its cycles to the cost. When an instruction finishes, the block reports its total cycle count and a flag telling whether it was pipelined with the instruction before it. Results come out in order, one pulse per instruction.

Top module: `lsu_issue_cost`

## Requirements
- R1: After reset no result is reported, `in_ready` is high and the history is empty, so the first memory access gets neither a reduction nor a penalty.
- R2: Class 0 (register-writing ALU op) and class 1 (op writing no register: compare, test, NOP, skipped conditional) each cost 1 cycle, and back-to-back 1-cycle instructions are accepted on consecutive cycles.
- R3: Class 3 (store), when not pipelined, costs 1 cycle with an immediate offset (`in_regoff`=0) and 2 cycles with a register offset (`in_regoff`=1).
- R4: Class 2 (load) to a register other than 15 without writeback costs 2 cycles when not pipelined.
- R5: A class 2, 3, 4 or 5 instruction without writeback that follows a load-like instruction (class 2 or 4, or class 5, none of them with writeback or destination 15) is pipelined when its address does not use that instruction's destination: its cost drops by one with a floor of 1, and `res_piped` is 1. Loads chain this way.
- R6: An address uses a register when the register equals `in_base`, or equals `in_off` with `in_regoff`=1. An immediate offset never creates a dependency, and a dependent access is not pipelined.
- R7: After any store of class 3 nothing is pipelined, and a store gets its reduction only after a load-like instruction.
- R8: A memory access (class 2 to 6) whose address uses the destination of an immediately preceding class 0 instruction costs one extra cycle.
- R9: Class 4 (exclusive load) and class 5 (exclusive store) are costed and pipelined exactly as a class 2 load, both as the earlier and as the later instruction of a pair.
- R10: A load-like instruction with `in_wb`=1 is never pipelined and costs 2 cycles. It drops to 1 when, during its second cycle, a valid class 1 descriptor is presented, which is then accepted in that same cycle. It leaves the history empty.
- R11: A class 2 load with destination 15 costs 5 cycles, class 7 (table branch) costs 6 and class 6 (doubleword access) costs 3. None of them is pipelined, and each leaves the history empty.
- R12: While `mem_stall` is high, `in_ready` is low, the remaining count is frozen and every stall cycle is added to the reported cost of the instruction in progress.
- R13: Each accepted instruction yields exactly one `res_valid` pulse, in order, in the cycle after its last issue cycle. An instruction accepted at clock edge k with total cost c reports in the cycle that follows edge k+c.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Descriptor present |
| in_ready | output | 1 | Descriptor accepted on this edge when valid |
| in_class | input | 3 | Instruction class code (0..7, see requirements) |
| in_dst | input | RIDX_W | Destination register index |
| in_base | input | RIDX_W | Base address register index |
| in_off | input | RIDX_W | Offset register index |
| in_wb | input | 1 | Base writeback flag |
| in_regoff | input | 1 | Offset comes from a register |
| mem_stall | input | 1 | Memory stall, extends the current cost |
| res_valid | output | 1 | Result pulse for one finished instruction |
| res_cost | output | CNT_W | Cycles the instruction held the issue slot |
| res_piped | output | 1 | Instruction was pipelined with its predecessor |

## Verification
An instruction accepted at edge k with cost c finishes at edge k+c, and its result is visible in the cycle after that edge. The driver reads a free-running cycle counter just after each accepting edge. It queues the expected cost and pipelined flag together with that due cycle, and the monitor compares all three at the falling edge when `res_valid` is seen. In the writeback case the bench presents the next descriptor in the load's second cycle. During a memory stall it samples `in_ready` at each falling edge.

// File: rtl/lsu_issue_cost.sv
`timescale 1ns/1ps
module lsu_issue_cost #(
  parameter int RIDX_W = 4,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [2:0]        in_class,
  input  logic [RIDX_W-1:0] in_dst,
  input  logic [RIDX_W-1:0] in_base,
  input  logic [RIDX_W-1:0] in_off,
  input  logic              in_wb,
  input  logic              in_regoff,
  input  logic              mem_stall,
  output logic              res_valid,
  output logic [CNT_W-1:0]  res_cost,
  output logic              res_piped
);
  localparam logic [RIDX_W-1:0] PC_IDX = RIDX_W'((1 << RIDX_W) - 1);
  localparam logic [2:0] K_ALU = 3'd0, K_NOWR = 3'd1, K_LD = 3'd2, K_ST = 3'd3,
                         K_LDX = 3'd4, K_STX = 3'd5, K_DBL = 3'd6, K_TBR = 3'd7;
  localparam logic [1:0] H_NONE = 2'd0, H_DP = 2'd1, H_LD = 2'd2;

  logic [1:0]        h_kind;
  logic [RIDX_W-1:0] h_dst;
  logic              busy, cur_wbld, cur_piped;
  logic [CNT_W-1:0]  left, spent;

  logic ldlike, is_mem, pc_ld, wb_ld, uses_h, dep_ld, dep_dp, can_pipe;
  logic drop, take, fin;
  logic [CNT_W-1:0] base_c, cost;

  assign ldlike   = (in_class == K_LD) || (in_class == K_LDX) || (in_class == K_STX);
  assign is_mem   = ldlike || (in_class == K_ST) || (in_class == K_DBL);
  assign pc_ld    = (in_class == K_LD) && (in_dst == PC_IDX);
  assign wb_ld    = ldlike && in_wb && !pc_ld;
  assign uses_h   = (in_base == h_dst) || (in_regoff && (in_off == h_dst));
  assign dep_ld   = (h_kind == H_LD) && uses_h;
  assign dep_dp   = (h_kind == H_DP) && uses_h;
  assign can_pipe = (h_kind == H_LD) && (ldlike || in_class == K_ST)
                    && !pc_ld && !in_wb && !dep_ld;

  always_comb begin
    case (in_class)
      K_ST:              base_c = in_regoff ? CNT_W'(2) : CNT_W'(1);
      K_LD, K_LDX, K_STX: base_c = pc_ld ? CNT_W'(5) : CNT_W'(2);
      K_DBL:             base_c = CNT_W'(3);
      K_TBR:             base_c = CNT_W'(6);
      default:           base_c = CNT_W'(1);
    endcase
    cost = base_c - CNT_W'(can_pipe && (base_c > CNT_W'(1))) + CNT_W'(is_mem && dep_dp);
  end

  assign drop     = busy && cur_wbld && (left == CNT_W'(1)) && in_valid && (in_class == K_NOWR);
  assign in_ready = !mem_stall && (!busy || (left == '0) || drop);
  assign take     = in_valid && in_ready;
  assign fin      = busy && !mem_stall && ((left == '0) || drop);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      left      <= '0;
      spent     <= '0;
      cur_wbld  <= 1'b0;
      cur_piped <= 1'b0;
      h_kind    <= H_NONE;
      h_dst     <= '0;
      res_valid <= 1'b0;
      res_cost  <= '0;
      res_piped <= 1'b0;
    end else begin
      res_valid <= fin;
      if (fin) begin
        res_cost  <= spent;
        res_piped <= cur_piped;
      end
      if (take) begin
        busy      <= 1'b1;
        left      <= cost - CNT_W'(1);
        spent     <= CNT_W'(1);
        cur_wbld  <= wb_ld;
        cur_piped <= can_pipe;
        h_dst     <= in_dst;
        if (in_class == K_ALU)
          h_kind <= H_DP;
        else if (ldlike && !pc_ld && !wb_ld)
          h_kind <= H_LD;
        else
          h_kind <= H_NONE;
      end else if (fin) begin
        busy <= 1'b0;
      end else if (busy) begin
        spent <= (&spent) ? spent : spent + CNT_W'(1);
        if (!mem_stall) left <= left - CNT_W'(1);
      end
    end
  end

  assert_stall_blocks_R12: assert property (@(posedge clk) disable iff (!rst_n)
    mem_stall |-> !in_ready);

  assert_stall_freezes_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && mem_stall) |=> $stable(left));

  assert_cost_nonzero_R13: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_cost != '0));

  assert_table_cost_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (take && in_class == K_TBR) |=> (left == CNT_W'(5)) && !cur_piped);

  assert_store_breaks_chain_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (take && in_class == K_ST) |=> (h_kind == H_NONE));
endmodule

// File: tb/lsu_issue_cost_bench.sv
`timescale 1ns/1ps
module lsu_issue_cost_bench;
  localparam logic [2:0] C_ALU = 3'd0, C_NOWR = 3'd1, C_LD = 3'd2, C_ST = 3'd3,
                         C_LDX = 3'd4, C_STX = 3'd5, C_DBL = 3'd6, C_TBR = 3'd7;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_wb = 1'b0, in_regoff = 1'b0, mem_stall = 1'b0;
  logic [2:0] in_class = 3'd0;
  logic [3:0] in_dst = '0, in_base = '0, in_off = '0;
  logic in_ready, res_valid, res_piped;
  logic [7:0] res_cost;

  int cyc = 0, checks = 0, errors = 0;
  int qcost[$], qdue[$];
  bit qpiped[$];
  string qreq[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  lsu_issue_cost u_lsu_issue_cost (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_class(in_class), .in_dst(in_dst), .in_base(in_base), .in_off(in_off),
    .in_wb(in_wb), .in_regoff(in_regoff), .mem_stall(mem_stall),
    .res_valid(res_valid), .res_cost(res_cost), .res_piped(res_piped));

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic send(input logic [2:0] c, input int d, input int b, input int o,
                      input bit wb, input bit rg, input int ecost, input bit epiped,
                      input string req);
    @(negedge clk);
    in_valid = 1'b1; in_class = c; in_dst = 4'(d); in_base = 4'(b);
    in_off = 4'(o); in_wb = wb; in_regoff = rg;
    forever begin
      #1;
      if (in_ready) begin
        @(posedge clk); #1;
        qcost.push_back(ecost); qpiped.push_back(epiped);
        qdue.push_back(cyc + ecost); qreq.push_back(req);
        break;
      end
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic stall(input int n);
    @(negedge clk);
    in_valid = 1'b0;
    mem_stall = 1'b1;
    #1 chk(in_ready == 1'b0, "R12", "ready during stall", int'(in_ready), 0);
    for (int i = 1; i < n; i++) begin
      @(negedge clk);
      #1 chk(in_ready == 1'b0, "R12", "ready during stall", int'(in_ready), 0);
    end
    @(negedge clk);
    mem_stall = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rst_n && res_valid) begin
      if (qcost.size() == 0) begin
        chk(1'b0, "R13", "unexpected result", int'(res_cost), 0);
      end else begin
        int ec, ed;
        bit ep;
        string r;
        ec = qcost.pop_front(); ep = qpiped.pop_front();
        ed = qdue.pop_front(); r = qreq.pop_front();
        chk(int'(res_cost) == ec, r, "cost", int'(res_cost), ec);
        chk(res_piped == ep, r, "piped", int'(res_piped), int'(ep));
        chk(cyc == ed, "R13", "result cycle", cyc, ed);
      end
    end
  end

  initial begin
    #100000;
    chk(1'b0, "R13", "watchdog expired", cyc, 0);
    report();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(in_ready == 1'b1, "R1", "ready after reset", int'(in_ready), 1);
    chk(res_valid == 1'b0, "R1", "no result after reset", int'(res_valid), 0);

    send(C_LD,  4, 0, 0, 0, 0, 2, 0, "R1");
    send(C_ALU, 1, 0, 0, 0, 0, 1, 0, "R2");
    send(C_NOWR,0, 0, 0, 0, 0, 1, 0, "R2");
    send(C_ST,  0, 2, 0, 0, 0, 1, 0, "R3");
    send(C_ST,  0, 2, 3, 0, 1, 2, 0, "R3");
    send(C_LD,  4, 5, 0, 0, 0, 2, 0, "R4");
    send(C_LD,  6, 7, 0, 0, 0, 1, 1, "R5");
    send(C_LD,  8, 9, 6, 0, 1, 2, 0, "R6");
    send(C_ST,  0,10, 8, 0, 0, 1, 1, "R6");
    send(C_LD,  3, 1, 0, 0, 0, 2, 0, "R7");
    send(C_ST,  0, 2, 4, 0, 1, 1, 1, "R5");
    send(C_ST,  0, 0, 0, 0, 0, 1, 0, "R7");
    send(C_ALU, 5, 0, 0, 0, 0, 1, 0, "R2");
    send(C_LD,  6, 5, 0, 0, 0, 3, 0, "R8");
    send(C_ALU, 7, 0, 0, 0, 0, 1, 0, "R2");
    send(C_ST,  0, 1, 7, 0, 1, 3, 0, "R8");
    send(C_ALU, 9, 0, 0, 0, 0, 1, 0, "R2");
    send(C_ST,  0, 2, 9, 0, 0, 1, 0, "R8");
    send(C_LDX, 2, 3, 0, 0, 0, 2, 0, "R9");
    send(C_STX, 4, 5, 0, 0, 0, 1, 1, "R9");
    send(C_LD,  6, 4, 0, 0, 0, 2, 0, "R9");
    send(C_STX, 7, 8, 0, 0, 0, 1, 1, "R9");
    send(C_LD,  6, 8, 0, 0, 0, 1, 1, "R9");
    send(C_LD,  1, 2, 0, 1, 0, 1, 0, "R10");
    send(C_NOWR,0, 0, 0, 0, 0, 1, 0, "R10");
    send(C_LD,  1, 2, 0, 1, 0, 2, 0, "R10");
    send(C_LD,  3, 4, 0, 0, 0, 2, 0, "R10");
    send(C_LD, 15, 2, 0, 0, 0, 5, 0, "R11");
    send(C_LD,  1, 2, 0, 0, 0, 2, 0, "R11");
    send(C_TBR, 0, 3, 4, 0, 1, 6, 0, "R11");
    send(C_LD,  1, 3, 0, 0, 0, 2, 0, "R11");
    send(C_DBL, 0, 4, 0, 0, 0, 3, 0, "R11");
    send(C_LD,  2, 5, 0, 0, 0, 2, 0, "R11");
    send(C_ALU, 4, 0, 0, 0, 0, 1, 0, "R8");
    send(C_DBL, 0, 4, 0, 0, 0, 4, 0, "R8");
    send(C_LD,  1, 2, 0, 0, 0, 4, 0, "R12");
    stall(2);
    idle();
    repeat (20) @(negedge clk);
    chk(qcost.size() == 0, "R13", "results outstanding", qcost.size(), 0);
    report();
  end
endmodule